// File: doc/BRIEF.md
# Predicated Subvector Loop Sequencer

This block walks one vector instruction whose elements are small subvectors of one to four components. It latches a configuration on a start pulse. The configuration holds an element count of 1 to 64, a subvector width of 1 to 4, a per-destination source selector and a predicate mask. The block then emits one operation request per component. Each request carries the element index, the destination component index, the source component chosen by the selector, an enable and a selector-error flag.

Masking is done per element. One predicate bit gates every component of its subvector. Masked elements are still walked in order, so a downstream datapath sees a fixed and predictable request count. The request output uses a valid/ready handshake, and a consumer that is not ready holds the walk in place. A one-cycle done pulse marks the end of the instruction. With an element count of one and a width of one, the block issues a single scalar request.

Top module: `subvec_seq`

## Requirements
- R1: `cfg_vl_m1` holds the element count minus one (0 means 1 element, 63 means 64). `cfg_sv_m1` holds the subvector width minus one (0 means 1 component, 3 means 4). Exactly (count × width) requests are accepted per instruction.
- R2: The first request after start is element 0, component 0. Components rise by one within an element. After the last component of an element, the walk moves to component 0 of the next element.
- R3: When bit e of the latched `cfg_pred` is 0, every request of element e has `req_en` = 0. The request is still presented and walked.
- R4: `req_src` equals field `cfg_swz[2d+1:2d]` of the latched selector, where d is `req_comp`.
- R5: When the selected source index exceeds `cfg_sv_m1`, that request has `req_swz_err` = 1 and `req_en` = 0, whatever the predicate bit.
- R6: In the cycle after the final request is accepted, `done` is 1 for exactly one cycle, and `busy` and `req_valid` are both 0.
- R7: A `start` that arrives while `busy` is 1 has no effect. This includes the cycle in which the final request is accepted. The running stream continues with the configuration latched first, and no new walk begins afterwards.
- R8: While `req_valid` is 1 and `req_ready` is 0, all request fields hold. No request is lost or repeated.
- R9: With `cfg_vl_m1` = 0 and `cfg_sv_m1` = 0, exactly one request (element 0, component 0) is issued, and then done follows.
- R10: After reset, `busy`, `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch configuration and begin a walk (ignored while busy) |
| cfg_vl_m1 | input | 6 | Element count minus one |
| cfg_sv_m1 | input | 2 | Subvector width minus one |
| cfg_swz | input | 8 | Source selector, 2 bits per destination component |
| cfg_pred | input | 64 | Predicate, one bit per element |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts request |
| req_elem | output | 6 | Element index |
| req_comp | output | 2 | Destination component index |
| req_src | output | 2 | Source component index |
| req_en | output | 1 | Request enabled (predicate true and selector legal) |
| req_swz_err | output | 1 | Selector names a component outside the subvector |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
Two events can fall in the same cycle: the acceptance of the final request and a fresh start pulse. The bench drives start high at the exact edge where it grants ready to the last request. It then checks that done rises and that no request appears for the following cycles. It also pulses start in the middle of a walk, while ready stalls at random, and checks that the remaining stream still matches the configuration latched first.

// File: rtl/subvec_seq_pkg.sv
package subvec_seq_pkg;

    localparam int unsigned DEF_VL_MAX = 64;
    localparam int unsigned DEF_SV_MAX = 4;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/subvec_seq_walk.sv
module subvec_seq_walk #(
    parameter int unsigned EW = 6,
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [EW-1:0] vl_m1,
    input  logic [CW-1:0] sv_m1,
    output logic [EW-1:0] elem,
    output logic [CW-1:0] comp,
    output logic          last
);

    typedef struct packed {
        logic [EW-1:0] elem;
        logic [CW-1:0] comp;
    } walk_t;

    walk_t st_d, st_q;

    logic comp_end;

    always_comb begin
        st_d     = st_q;
        comp_end = (st_q.comp == sv_m1);
        if (load) begin
            st_d.elem = '0;
            st_d.comp = '0;
        end else if (step) begin
            if (comp_end) begin
                st_d.comp = '0;
                st_d.elem = st_q.elem + 1'b1;
            end else begin
                st_d.comp = st_q.comp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elem = st_q.elem;
    assign comp = st_q.comp;
    assign last = comp_end && (st_q.elem == vl_m1);

    // R2: component advances by one inside an element
    p_comp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last && comp != sv_m1)
        |=> (comp == $past(comp) + 1'b1) && (elem == $past(elem)));

    // R2: element boundary wraps the component and bumps the element
    p_elem_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last && comp == sv_m1)
        |=> (comp == '0) && (elem == $past(elem) + 1'b1));

    // R1: component never leaves the configured width during a walk
    p_comp_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> comp <= sv_m1);

endmodule

// File: rtl/subvec_seq_lane.sv
module subvec_seq_lane #(
    parameter int unsigned SV_MAX = 4,
    parameter int unsigned CW     = 2
) (
    input  logic [SV_MAX*CW-1:0] swz,
    input  logic [CW-1:0]        sv_m1,
    input  logic [CW-1:0]        comp,
    input  logic                 pred_bit,
    output logic [CW-1:0]        src,
    output logic                 en,
    output logic                 err
);

    logic [CW-1:0]     sel [SV_MAX];
    logic [SV_MAX-1:0] bad;

    for (genvar d = 0; d < SV_MAX; d++) begin : g_dst
        assign sel[d] = swz[d*CW +: CW];
        assign bad[d] = (sel[d] > sv_m1);
    end

    always_comb begin
        src = sel[comp];
        err = bad[comp];
        en  = pred_bit && !err;
    end

endmodule

// File: rtl/subvec_seq.sv
module subvec_seq
    import subvec_seq_pkg::*;
#(
    parameter int unsigned VL_MAX = DEF_VL_MAX,
    parameter int unsigned SV_MAX = DEF_SV_MAX
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [$clog2(VL_MAX)-1:0]       cfg_vl_m1,
    input  logic [$clog2(SV_MAX)-1:0]       cfg_sv_m1,
    input  logic [SV_MAX*$clog2(SV_MAX)-1:0] cfg_swz,
    input  logic [VL_MAX-1:0]               cfg_pred,
    output logic                            busy,
    output logic                            req_valid,
    input  logic                            req_ready,
    output logic [$clog2(VL_MAX)-1:0]       req_elem,
    output logic [$clog2(SV_MAX)-1:0]       req_comp,
    output logic [$clog2(SV_MAX)-1:0]       req_src,
    output logic                            req_en,
    output logic                            req_swz_err,
    output logic                            done
);

    localparam int unsigned EW = $clog2(VL_MAX);
    localparam int unsigned CW = $clog2(SV_MAX);
    localparam int unsigned SW = SV_MAX * CW;

    typedef struct packed {
        seq_state_e    st;
        logic          done;
        logic [EW-1:0] vl_m1;
        logic [CW-1:0] sv_m1;
        logic [SW-1:0] swz;
        logic [VL_MAX-1:0] pred;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          load;
    logic          fire;
    logic          last;
    logic [EW-1:0] elem;
    logic [CW-1:0] comp;

    assign load = (ctl_q.st == S_IDLE) && start;
    assign fire = req_valid && req_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (load) begin
            ctl_d.st    = S_RUN;
            ctl_d.vl_m1 = cfg_vl_m1;
            ctl_d.sv_m1 = cfg_sv_m1;
            ctl_d.swz   = cfg_swz;
            ctl_d.pred  = cfg_pred;
        end else if (ctl_q.st == S_RUN && fire && last) begin
            ctl_d.st   = S_IDLE;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    subvec_seq_walk #(
        .EW (EW),
        .CW (CW)
    ) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (fire),
        .vl_m1 (ctl_q.vl_m1),
        .sv_m1 (ctl_q.sv_m1),
        .elem  (elem),
        .comp  (comp),
        .last  (last)
    );

    subvec_seq_lane #(
        .SV_MAX (SV_MAX),
        .CW     (CW)
    ) u_lane (
        .swz      (ctl_q.swz),
        .sv_m1    (ctl_q.sv_m1),
        .comp     (comp),
        .pred_bit (ctl_q.pred[elem]),
        .src      (req_src),
        .en       (req_en),
        .err      (req_swz_err)
    );

    assign busy      = (ctl_q.st == S_RUN);
    assign req_valid = busy;
    assign req_elem  = elem;
    assign req_comp  = comp;
    assign done      = ctl_q.done;

    // R8: a stalled request keeps every field
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready)
        |=> req_valid && $stable(req_elem) && $stable(req_comp)
            && $stable(req_src) && $stable(req_en) && $stable(req_swz_err));

    // R6: final acceptance is followed by done with the request side idle
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> done && !req_valid && !busy);

    // R6: done lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: start during a walk leaves the latched configuration alone
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start)
        |=> $stable(ctl_q.vl_m1) && $stable(ctl_q.sv_m1)
            && $stable(ctl_q.swz) && $stable(ctl_q.pred));

    // R3: a cleared predicate bit mutes its element
    p_pred_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_q.pred[req_elem]) |-> !req_en);

    // R5: a selector error never carries an enable
    p_err_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_swz_err |-> !req_en);

    // R2: a walk opens at element 0, component 0
    p_first_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (req_elem == '0) && (req_comp == '0));

endmodule

// File: tb/subvec_seq_bench.sv
module subvec_seq_bench;

    localparam int unsigned VL_MAX = 64;
    localparam int unsigned SV_MAX = 4;
    localparam int unsigned EW = $clog2(VL_MAX);
    localparam int unsigned CW = $clog2(SV_MAX);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [EW-1:0]     cfg_vl_m1 = '0;
    logic [CW-1:0]     cfg_sv_m1 = '0;
    logic [SV_MAX*CW-1:0] cfg_swz = '0;
    logic [VL_MAX-1:0] cfg_pred = '0;
    logic              busy, req_valid, req_en, req_swz_err, done;
    logic              req_ready = 1'b0;
    logic [EW-1:0]     req_elem;
    logic [CW-1:0]     req_comp, req_src;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    subvec_seq u_subvec_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_vl_m1   (cfg_vl_m1),
        .cfg_sv_m1   (cfg_sv_m1),
        .cfg_swz     (cfg_swz),
        .cfg_pred    (cfg_pred),
        .busy        (busy),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_elem    (req_elem),
        .req_comp    (req_comp),
        .req_src     (req_src),
        .req_en      (req_en),
        .req_swz_err (req_swz_err),
        .done        (done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // packs {valid, elem, comp, src, en, err}
    function automatic logic [31:0] exp_req(input int k, input int vl_m1, input int sv_m1,
                                            input logic [7:0] swz, input logic [63:0] pred);
        int sv, e, c, s;
        bit er, en;
        sv = sv_m1 + 1;
        e  = k / sv;
        c  = k % sv;
        s  = (swz >> (2 * c)) & 3;
        er = (s > sv_m1);
        en = pred[e] && !er;
        return {19'd0, 1'b1, e[5:0], c[1:0], s[1:0], en, er};
    endfunction

    task automatic run_job(input int vl_m1, input int sv_m1, input logic [7:0] swz,
                           input logic [63:0] pred, input int stall_pct,
                           input bit poke_mid, input bit poke_last);
        int total, k;
        bit rdy;
        logic [31:0] act, exp;
        total = (vl_m1 + 1) * (sv_m1 + 1);
        @(negedge clk);
        cfg_vl_m1 = vl_m1[EW-1:0];
        cfg_sv_m1 = sv_m1[CW-1:0];
        cfg_swz   = swz;
        cfg_pred  = pred;
        start     = 1'b1;
        req_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (k < total) begin
            act = {19'd0, req_valid, req_elem, req_comp, req_src, req_en, req_swz_err};
            exp = exp_req(k, vl_m1, sv_m1, swz, pred);
            // R2 R3 R4 R5 R8: field check of request k (also after stalls)
            check(act == exp, "R2/R3/R4/R5/R8", $sformatf("request %0d", k), act, exp);
            rdy = ($urandom_range(99) >= stall_pct);
            req_ready = rdy;
            if (poke_mid && k == 1) begin
                // R7: start while busy with a different configuration
                start     = 1'b1;
                cfg_vl_m1 = ~cfg_vl_m1;
                cfg_sv_m1 = ~cfg_sv_m1;
                cfg_swz   = ~cfg_swz;
                cfg_pred  = ~cfg_pred;
            end
            if (poke_last && rdy && k == total - 1) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (rdy) k++;
        end
        req_ready = 1'b0;
        // R1 R6: done right after the final acceptance
        check(done == 1'b1, "R1/R6", "done after last", {31'd0, done}, 32'd1);
        check(!req_valid && !busy, "R6", "idle with done",
              {30'd0, req_valid, busy}, 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R6", "done single pulse", {31'd0, done}, 32'd0);
        if (poke_last || poke_mid) begin
            // R7: the ignored start must not open another walk
            check(!req_valid && !busy, "R7", "no walk from ignored start",
                  {30'd0, req_valid, busy}, 32'd0);
            @(negedge clk);
            check(!req_valid, "R7", "still idle", {31'd0, req_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !req_valid && !done, "R10", "reset outputs",
              {29'd0, busy, req_valid, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R10", "after reset release",
              {29'd0, busy, req_valid, done}, 32'd0);

        // R9: scalar instruction
        run_job(0, 0, 8'b11_10_01_00, 64'h1, 0, 1'b0, 1'b0);
        // R1: full length, full width, identity selector, all enabled
        run_job(63, 3, 8'b11_10_01_00, {64{1'b1}}, 0, 1'b0, 1'b0);
        // R5: width 2 with out-of-range selectors on destinations 2 and 3 and a legal swap
        run_job(5, 1, {2'd3, 2'd2, 2'd0, 2'd1}, 64'h2A, 30, 1'b0, 1'b0);
        // R5: width 3, destination 1 names component 3
        run_job(3, 2, {2'd0, 2'd2, 2'd3, 2'd0}, 64'hF, 0, 1'b0, 1'b0);
        // R3: alternating predicate with stalls
        run_job(15, 3, 8'b00_01_10_11, 64'h5555, 50, 1'b0, 1'b0);
        // R7: start in the final acceptance cycle, and in the middle
        run_job(2, 1, 8'b01_00_01_00, 64'h5, 0, 1'b0, 1'b1);
        run_job(4, 2, 8'b00_10_01_00, 64'h1B, 40, 1'b1, 1'b1);
        // R8: heavy stalling
        run_job(7, 3, 8'b10_11_00_01, 64'hC3, 80, 1'b0, 1'b0);

        for (int j = 0; j < 30; j++) begin
            run_job($urandom_range(63), $urandom_range(3), 8'($urandom),
                    {$urandom, $urandom}, $urandom_range(70),
                    1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule